// File: doc/BRIEF.md
# Clock-Crossing Control Register for a Serial Peripheral

This block holds the control word of a serial peripheral whose core runs on a clock unrelated to the register bus. The control word has three parts: a mode field that picks how the peripheral is clocked, an enable bit, and a software reset bit. The bus side stores each accepted write at once and reads it back on the next cycle. The enable and reset requests travel into the core domain through a toggle handshake, and a busy flag stays raised while a request is still in transit.

Only the enable and reset actions cross the clock boundary. The mode field goes straight from the bus-side register to its output. A reset write sends every control field back to its idle value and discards the other bits of that write. A separate debug-control register is not affected by the software reset. Software must wait until busy is low before it writes the control word again. A control write made while busy is high is dropped.

Top module: `ctrl_cdc_regfile`

## Requirements
- R1: After the power-on resets, all three readable addresses return 0, and `busy`, `core_enable` and `core_reset` are low.
- R2: A control write (`wr_addr` = 0) with bit 0 clear stores bits [3:2] as the mode. The mode reads back in `rd_data[3:2]` and appears on `mode_o` from the next bus edge, without passing through the core domain. Code 0 selects an external clock, code 1 an internally generated clock, and codes 2 and 3 are stored as written.
- R3: An accepted control write raises `busy` (`rd_data[0]` at status address 1) from the bus edge that takes the write. `busy` stays high until the core domain has acted on the request, and it then falls without any further stimulus.
- R4: The enable bit (bit 1) reads back the written value from the next bus edge while `busy` is still high. `core_enable` takes the same value by the time `busy` falls.
- R5: A control write with bit 0 set discards its other bits. Mode and enable become 0, and bit 0 reads 1 while `busy` is high. `core_reset` is then high for exactly RST_HOLD core cycles, and `core_enable` is low for that whole time. Bit 0 and `busy` read 0 together once the reset has finished.
- R6: A control write that arrives while `busy` is high is ignored completely: mode, enable and the reset bit keep their values.
- R7: A control write with bit 0 clear never asserts `core_reset`.
- R8: The debug register at address 2, bits [DBG_W-1:0], drives `dbg_o`. It accepts writes even while `busy` is high and keeps its value through a software reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 2 debug |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 status, 2 debug |
| rd_data | output | DATA_W | Read data (combinational) |
| busy | output | 1 | A handshake is in flight |
| mode_o | output | MODE_W | Mode field, taken directly from the bus register |
| dbg_o | output | DBG_W | Debug-control register |
| core_clk | input | 1 | Peripheral core clock |
| core_rst_n | input | 1 | Active-low asynchronous reset, core domain |
| core_enable | output | 1 | Enable, synchronized into the core domain |
| core_reset | output | 1 | Software reset pulse in the core domain |

## Verification
Results on the bus side are due one bus edge after the write: the read-back, `mode_o` and `busy`. The bench drives each write at a falling edge and samples just after the next falling edge. The core-side results depend on the ratio of the two clocks, so the bench waits for `busy` to fall, with a cycle limit on the wait. It checks `core_enable` and the final read-back only after that point, because the acknowledge is sent after the core has updated. The `core_reset` high time is counted on every falling core-clock edge and compared with RST_HOLD. The second write of each pattern is issued one bus cycle after the first. A full round trip through the handshake takes far longer than that, so the second write is certain to land while busy is high.

// File: rtl/ctrl_sync_pkg.sv
package ctrl_sync_pkg;
    // register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DBG  = 2'd2;
    // control word bit positions
    localparam int BIT_RST  = 0;
    localparam int BIT_EN   = 1;
    localparam int BIT_MODE = 2;
    // status word bit position
    localparam int BIT_BUSY = 0;
endpackage

// File: rtl/ctrl_sync_bit.sv
// Two-flop synchronizer for single-bit toggle signals.
module ctrl_sync_bit #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/ctrl_bus_side.sv
// Bus-domain register file: control word, debug register, request toggle.
module ctrl_bus_side
    import ctrl_sync_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int DBG_W  = 1,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    input  logic              ack_sync,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [MODE_W-1:0] mode_o,
    output logic [DBG_W-1:0]  dbg_o,
    output logic              req_tgl,
    output logic              pay_en,
    output logic              pay_rst
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              en;
        logic              rst_pend;
        logic              req;
        logic [DBG_W-1:0]  dbg;
    } bus_state_t;

    bus_state_t st_d, st_q;
    logic       busy_w;
    logic       unused_wr;

    assign unused_wr = ^wr_data;
    assign busy_w    = st_q.req ^ ack_sync;

    always_comb begin
        st_d = st_q;
        // the reset-pending flag ends when the acknowledge arrives
        if (!busy_w) st_d.rst_pend = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                if (!busy_w) begin
                    st_d.req = ~st_q.req;
                    if (wr_data[BIT_RST]) begin
                        // reset wins: every other bit of this write is dropped
                        st_d.mode     = '0;
                        st_d.en       = 1'b0;
                        st_d.rst_pend = 1'b1;
                    end else begin
                        st_d.mode = wr_data[BIT_MODE +: MODE_W];
                        st_d.en   = wr_data[BIT_EN];
                    end
                end
            end else if (wr_addr == ADDR_DBG) begin
                st_d.dbg = wr_data[DBG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: begin
                rd_data[BIT_RST]               = st_q.rst_pend & busy_w;
                rd_data[BIT_EN]                = st_q.en;
                rd_data[BIT_MODE +: MODE_W]    = st_q.mode;
            end
            ADDR_STAT: rd_data[BIT_BUSY]       = busy_w;
            ADDR_DBG:  rd_data[DBG_W-1:0]      = st_q.dbg;
            default:   rd_data                 = '0;
        endcase
    end

    assign busy    = busy_w;
    assign mode_o  = st_q.mode;
    assign dbg_o   = st_q.dbg;
    assign req_tgl = st_q.req;
    // payload is held steady while busy, so the core samples it after the toggle
    assign pay_en  = st_q.en;
    assign pay_rst = st_q.rst_pend;
endmodule

// File: rtl/ctrl_core_side.sv
// Core-domain receiver: applies enable, times the reset, returns the acknowledge.
module ctrl_core_side #(
    parameter int RST_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    input  logic pay_en,
    input  logic pay_rst,
    output logic ack_tgl,
    output logic core_enable,
    output logic core_reset
);
    localparam int CNT_W = $clog2(RST_HOLD + 1);

    typedef struct packed {
        logic             seen;
        logic             ack;
        logic             en;
        logic [CNT_W-1:0] cnt;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) st_d.ack = st_q.seen;
        end else if (req_sync != st_q.seen) begin
            st_d.seen = req_sync;
            if (pay_rst) begin
                st_d.en  = 1'b0;
                st_d.cnt = CNT_W'(RST_HOLD);
            end else begin
                st_d.en  = pay_en;
                st_d.ack = req_sync;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tgl     = st_q.ack;
    assign core_enable = st_q.en;
    assign core_reset  = (st_q.cnt != '0);
endmodule

// File: rtl/ctrl_cdc_regfile.sv
module ctrl_cdc_regfile #(
    parameter int MODE_W   = 2,
    parameter int DBG_W    = 1,
    parameter int DATA_W   = 8,
    parameter int RST_HOLD = 4
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [MODE_W-1:0] mode_o,
    output logic [DBG_W-1:0]  dbg_o,
    input  logic              core_clk,
    input  logic              core_rst_n,
    output logic              core_enable,
    output logic              core_reset
);
    logic req_tgl, req_sync, ack_tgl, ack_sync;
    logic pay_en, pay_rst;

    ctrl_bus_side #(
        .MODE_W(MODE_W), .DBG_W(DBG_W), .DATA_W(DATA_W)
    ) u_bus (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .ack_sync(ack_sync),
        .rd_data(rd_data), .busy(busy), .mode_o(mode_o), .dbg_o(dbg_o),
        .req_tgl(req_tgl), .pay_en(pay_en), .pay_rst(pay_rst)
    );

    ctrl_sync_bit #(.W(1)) u_req_sync (
        .clk(core_clk), .rst_n(core_rst_n), .d(req_tgl), .q(req_sync)
    );

    ctrl_core_side #(.RST_HOLD(RST_HOLD)) u_core (
        .clk(core_clk), .rst_n(core_rst_n),
        .req_sync(req_sync), .pay_en(pay_en), .pay_rst(pay_rst),
        .ack_tgl(ack_tgl), .core_enable(core_enable), .core_reset(core_reset)
    );

    ctrl_sync_bit #(.W(1)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_sync)
    );
endmodule

// File: rtl/ctrl_cdc_regfile_chk.sv
module ctrl_cdc_regfile_chk
    import ctrl_sync_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int DBG_W  = 1,
    parameter int DATA_W = 8
) (
    input logic              bus_clk,
    input logic              bus_rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic [MODE_W-1:0] mode_o,
    input logic [DBG_W-1:0]  dbg_o,
    input logic              core_clk,
    input logic              core_rst_n,
    input logic              core_enable,
    input logic              core_reset
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

    a_r3_busy_on_write: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (ctrl_wr && !busy) |=> busy);

    a_r6_ignored_while_busy: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (ctrl_wr && busy) |=> $stable(mode_o));

    a_r5_reset_clears_mode: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (ctrl_wr && !busy && wr_data[BIT_RST]) |=> (mode_o == '0));

    a_r8_debug_survives: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (ctrl_wr && !busy && wr_data[BIT_RST]) |=> $stable(dbg_o));

    a_r5_disabled_in_reset: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        core_reset |-> !core_enable);
endmodule

bind ctrl_cdc_regfile ctrl_cdc_regfile_chk #(
    .MODE_W(MODE_W), .DBG_W(DBG_W), .DATA_W(DATA_W)
) u_chk (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .mode_o(mode_o), .dbg_o(dbg_o),
    .core_clk(core_clk), .core_rst_n(core_rst_n),
    .core_enable(core_enable), .core_reset(core_reset)
);

// File: tb/ctrl_cdc_regfile_test.sv
`timescale 1ns/10ps
module ctrl_cdc_regfile_test;
    localparam int RST_HOLD = 4;

    logic       bus_clk = 1'b0, core_clk = 1'b0;
    logic       bus_rst_n = 1'b0, core_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       busy, core_enable, core_reset;
    logic [1:0] mode_o;
    logic [0:0] dbg_o;

    int n_chk = 0, n_fail = 0;
    int rst_cyc = 0, en_in_rst = 0;
    bit done = 1'b0;

    always #2.5  bus_clk  = ~bus_clk;   // 200 MHz
    always #3.65 core_clk = ~core_clk;  // unrelated core clock

    ctrl_cdc_regfile #(.MODE_W(2), .DBG_W(1), .DATA_W(8), .RST_HOLD(RST_HOLD)) uut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .mode_o(mode_o), .dbg_o(dbg_o), .core_clk(core_clk), .core_rst_n(core_rst_n),
        .core_enable(core_enable), .core_reset(core_reset)
    );

    always @(negedge core_clk) begin
        if (core_reset) begin
            rst_cyc++;
            if (core_enable) en_in_rst++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 300) begin
            @(negedge bus_clk);
            n++;
        end
        check(!busy, "R3", "busy did not fall", int'(busy), 0);
        @(negedge bus_clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge bus_clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge core_clk);
        core_rst_n = 1'b1;
        repeat (3) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        @(negedge bus_clk);

        // R1 reset state
        rd(2'd0, v); check(v == 8'd0, "R1", "ctrl after reset", v, 0);
        rd(2'd1, v); check(v == 8'd0, "R1", "status after reset", v, 0);
        rd(2'd2, v); check(v == 8'd0, "R1", "debug after reset", v, 0);
        check(!busy && !core_enable && !core_reset, "R1", "outputs after reset",
              {busy, core_enable, core_reset}, 0);

        // plain writes: every mode code with both enable values
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                logic [7:0] exp_c;
                exp_c = 8'((m << 2) | (e << 1));
                rst_cyc = 0;
                @(negedge bus_clk);
                bus_write(2'd0, exp_c);
                rd(2'd0, v);
                check(v == exp_c, "R4", "ctrl readback while busy", v, exp_c);
                check(mode_o == 2'(m), "R2", "mode_o after write", mode_o, m);
                rd(2'd1, v);
                check(v == 8'd1, "R3", "busy on write cycle", v, 1);
                // second write inside the busy window must be dropped
                bus_write(2'd0, 8'(((3 - m) << 2) | ((1 - e) << 1)));
                rd(2'd0, v);
                check(v == exp_c, "R6", "ctrl after write while busy", v, exp_c);
                check(mode_o == 2'(m), "R6", "mode_o after write while busy", mode_o, m);
                wait_idle();
                check(core_enable == e[0], "R4", "core_enable after handshake", core_enable, e);
                rd(2'd0, v);
                check(v == exp_c, "R2", "ctrl after handshake", v, exp_c);
                check(rst_cyc == 0, "R7", "core_reset cycles for plain write", rst_cyc, 0);
            end
        end

        // reset writes: reset wins over mode and enable in the same access
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                logic [0:0] dv;
                dv = 1'(m ^ e);
                bus_write(2'd2, {7'd0, dv});
                bus_write(2'd0, 8'((m << 2) | 2));
                wait_idle();
                check(core_enable, "R4", "core enabled before reset", core_enable, 1);
                rst_cyc = 0; en_in_rst = 0;
                bus_write(2'd0, 8'((m << 2) | (e << 1) | 1));
                rd(2'd0, v);
                check(v == 8'd1, "R5", "ctrl during reset", v, 1);
                check(mode_o == 2'd0, "R5", "mode_o during reset", mode_o, 0);
                rd(2'd1, v);
                check(v == 8'd1, "R3", "busy after reset write", v, 1);
                bus_write(2'd2, {7'd0, ~dv});
                check(dbg_o == ~dv, "R8", "debug write while busy", dbg_o, ~dv);
                wait_idle();
                rd(2'd0, v);
                check(v == 8'd0, "R5", "ctrl after reset done", v, 0);
                check(!core_enable, "R5", "core_enable after reset", core_enable, 0);
                check(rst_cyc == RST_HOLD, "R5", "core_reset length", rst_cyc, RST_HOLD);
                check(en_in_rst == 0, "R5", "enable high during reset", en_in_rst, 0);
                rd(2'd2, v);
                check(v[0] == ~dv, "R8", "debug kept through reset", v[0], ~dv);
            end
        end

        // a reset bit written as 0 has no reset effect
        rst_cyc = 0;
        bus_write(2'd0, 8'h04);
        wait_idle();
        check(rst_cyc == 0, "R7", "zero reset bit", rst_cyc, 0);
        check(mode_o == 2'd1, "R2", "internal clock mode", mode_o, 1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule